// File: doc/BRIEF.md
# Multicart Bank-Switching Mapper

This block sits on the cartridge side of a game console bus. It watches CPU writes into the upper half of the CPU address space and keeps two 8-bit control registers. From these registers it forms the upper address bits for the program ROM and the character ROM, and it drives a flag that selects horizontal or vertical nametable mirroring. The low address bits of both ROMs come straight from the CPU and PPU address buses.

The two registers share one write window. CPU address bit 11 chooses which register a write loads. A mode bit in the first register decides which register supplies the two low character bank bits. Program space is mapped either as one 16 KiB bank seen in both halves or as an aligned 32 KiB pair. A restore port loads both registers in one cycle, and two read-back ports expose them, so the mapping can be saved and brought back.

Top module: `multicart_mapper`

## Requirements
- R1: While reset is active (asynchronous, active low), both registers read zero. This gives program bank 0 in both halves, character bank 0 and vertical mirroring (`mirror_h_o`=0).
- R2: A write with CPU address bit 15 set loads register A (`snap_chr_o`) when address bit 11 is 0 and register B (`snap_main_o`) when bit 11 is 1. The new value and the new mapping appear only after the clock edge that samples the write strobe.
- R3: A write with CPU address bit 15 clear changes neither register.
- R4: Character bank = {A[6], B[2], low}, 4 bits. `chr_addr_o[16:13]` carries it. When the mode bit A[7] is 0, low is A[1:0].
- R5: When A[7] is 1, the low two character bank bits come from B[1:0].
- R6: When B[4] is 0, the 3-bit program bank B[7:5] drives `prg_addr_o[16:14]` for both CPU address halves (bit 14 of the CPU address is 0 or 1).
- R7: When B[4] is 1, the CPU half with address bit 14 = 0 maps bank B[7:5] with bit 0 cleared, and the half with bit 14 = 1 maps it with bit 0 set.
- R8: `mirror_h_o` equals B[3]: 1 is horizontal, 0 is vertical.
- R9: `prg_addr_o[13:0]` equals CPU address bits 13:0, and `chr_addr_o[12:0]` equals PPU address bits 12:0.
- R10: With `restore_i` high at a clock edge, both registers take `restore_chr_i` and `restore_main_i`, and all outputs follow right after that edge.
- R11: If a restore and a CPU register write fall on the same edge, the restore values win for both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_data_i | input | 8 | CPU write data |
| cpu_wr_i | input | 1 | CPU write strobe, sampled on the rising edge |
| ppu_addr_i | input | 13 | PPU address within the 8 KiB pattern window |
| restore_i | input | 1 | Load both registers from the restore inputs |
| restore_chr_i | input | 8 | Restore value for register A |
| restore_main_i | input | 8 | Restore value for register B |
| snap_chr_o | output | 8 | Read-back of register A |
| snap_main_o | output | 8 | Read-back of register B |
| prg_addr_o | output | 17 | Program ROM address: bank bits and offset |
| chr_addr_o | output | 17 | Character ROM address: bank bits and offset |
| mirror_h_o | output | 1 | Nametable mirroring select, 1 for horizontal |

## Verification
The state restore and a CPU register write can land on the same clock edge. Each one loads the same two registers. The bench raises `restore_i` in the same cycle as a write of all ones to register B. It then expects both read-back ports and the decoded bank outputs to hold the restore values alone. A second case shows the write window still works on the next cycle, and a bound property checks on every restore edge that the registers hold the sampled restore inputs.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

  localparam int unsigned REG_W      = 8;
  localparam int unsigned PRG_BANK_W = 3;
  localparam int unsigned CHR_BANK_W = 4;

  // register A: character control
  typedef struct packed {
    logic       lo_from_b;   // 1: low chr bits from register B
    logic       chr_a16;
    logic [3:0] rsvd;
    logic [1:0] chr_lo;
  } chr_ctl_t;

  // register B: program / mirroring control
  typedef struct packed {
    logic [2:0] prg_bank;
    logic       prg_wide;    // 1: aligned 32 KiB pair
    logic       mir_h;
    logic       chr_a15;
    logic [1:0] chr_lo;
  } main_ctl_t;

endpackage

// File: rtl/mcm_regs.sv
module mcm_regs
  import mcm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_i,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] data_i,
  input  logic             restore_i,
  input  logic [REG_W-1:0] restore_a_i,
  input  logic [REG_W-1:0] restore_b_i,
  output chr_ctl_t         chr_ctl_o,
  output main_ctl_t        main_ctl_o
);

  localparam int unsigned NREG = 2;

  logic [NREG-1:0][REG_W-1:0] regs_q;
  logic [NREG-1:0][REG_W-1:0] rest_val;

  assign rest_val[0] = restore_a_i;
  assign rest_val[1] = restore_b_i;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic wr_en;
    assign wr_en = wr_i & win_i & (sel_i == 1'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        regs_q[g] <= '0;
      else if (restore_i) regs_q[g] <= rest_val[g];  // restore has priority
      else if (wr_en)     regs_q[g] <= data_i;
    end
  end

  assign chr_ctl_o  = chr_ctl_t'(regs_q[0]);
  assign main_ctl_o = main_ctl_t'(regs_q[1]);

endmodule

// File: rtl/mcm_prg_map.sv
module mcm_prg_map
  import mcm_pkg::*;
#(
  parameter int unsigned OFS_W = 14
) (
  input  logic [PRG_BANK_W-1:0]       bank_i,
  input  logic                        wide_i,
  input  logic                        half_i,
  input  logic [OFS_W-1:0]            ofs_i,
  output logic [PRG_BANK_W+OFS_W-1:0] addr_o
);

  logic [PRG_BANK_W-1:0] bank_eff;

  always_comb begin
    if (wide_i) bank_eff = {bank_i[PRG_BANK_W-1:1], half_i};
    else        bank_eff = bank_i;
  end

  assign addr_o = {bank_eff, ofs_i};

endmodule

// File: rtl/mcm_chr_map.sv
module mcm_chr_map
  import mcm_pkg::*;
#(
  parameter int unsigned OFS_W = 13
) (
  input  logic                        lo_from_b_i,
  input  logic                        a16_i,
  input  logic                        a15_i,
  input  logic [1:0]                  lo_a_i,
  input  logic [1:0]                  lo_b_i,
  input  logic [OFS_W-1:0]            ofs_i,
  output logic [CHR_BANK_W+OFS_W-1:0] addr_o
);

  logic [1:0] lo_sel;

  assign lo_sel = lo_from_b_i ? lo_b_i : lo_a_i;
  assign addr_o = {a16_i, a15_i, lo_sel, ofs_i};

endmodule

// File: rtl/multicart_mapper.sv
module multicart_mapper
  import mcm_pkg::*;
#(
  parameter int unsigned PRG_OFS_W = 14,
  parameter int unsigned CHR_OFS_W = 13,
  parameter int unsigned SEL_BIT   = 11,
  localparam int unsigned CPU_AW   = 16,
  localparam int unsigned PRG_AW   = PRG_BANK_W + PRG_OFS_W,
  localparam int unsigned CHR_AW   = CHR_BANK_W + CHR_OFS_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CPU_AW-1:0]    cpu_addr_i,
  input  logic [REG_W-1:0]     cpu_data_i,
  input  logic                 cpu_wr_i,
  input  logic [CHR_OFS_W-1:0] ppu_addr_i,
  input  logic                 restore_i,
  input  logic [REG_W-1:0]     restore_chr_i,
  input  logic [REG_W-1:0]     restore_main_i,
  output logic [REG_W-1:0]     snap_chr_o,
  output logic [REG_W-1:0]     snap_main_o,
  output logic [PRG_AW-1:0]    prg_addr_o,
  output logic [CHR_AW-1:0]    chr_addr_o,
  output logic                 mirror_h_o
);

  chr_ctl_t  chr_ctl;
  main_ctl_t main_ctl;

  mcm_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_i       (cpu_addr_i[CPU_AW-1]),
    .sel_i       (cpu_addr_i[SEL_BIT]),
    .wr_i        (cpu_wr_i),
    .data_i      (cpu_data_i),
    .restore_i   (restore_i),
    .restore_a_i (restore_chr_i),
    .restore_b_i (restore_main_i),
    .chr_ctl_o   (chr_ctl),
    .main_ctl_o  (main_ctl)
  );

  mcm_prg_map #(.OFS_W(PRG_OFS_W)) u_prg (
    .bank_i (main_ctl.prg_bank),
    .wide_i (main_ctl.prg_wide),
    .half_i (cpu_addr_i[PRG_OFS_W]),
    .ofs_i  (cpu_addr_i[PRG_OFS_W-1:0]),
    .addr_o (prg_addr_o)
  );

  mcm_chr_map #(.OFS_W(CHR_OFS_W)) u_chr (
    .lo_from_b_i (chr_ctl.lo_from_b),
    .a16_i       (chr_ctl.chr_a16),
    .a15_i       (main_ctl.chr_a15),
    .lo_a_i      (chr_ctl.chr_lo),
    .lo_b_i      (main_ctl.chr_lo),
    .ofs_i       (ppu_addr_i),
    .addr_o      (chr_addr_o)
  );

  assign snap_chr_o  = chr_ctl;
  assign snap_main_o = main_ctl;
  assign mirror_h_o  = main_ctl.mir_h;

endmodule

// File: rtl/mcm_checker.sv
module mcm_checker #(
  parameter int unsigned PRG_OFS_W = 14,
  parameter int unsigned CHR_OFS_W = 13,
  localparam int unsigned PRG_AW   = 3 + PRG_OFS_W,
  localparam int unsigned CHR_AW   = 4 + CHR_OFS_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [15:0]          cpu_addr_i,
  input logic [7:0]           cpu_data_i,
  input logic                 cpu_wr_i,
  input logic [CHR_OFS_W-1:0] ppu_addr_i,
  input logic                 restore_i,
  input logic [7:0]           restore_chr_i,
  input logic [7:0]           restore_main_i,
  input logic [7:0]           snap_chr_o,
  input logic [7:0]           snap_main_o,
  input logic [PRG_AW-1:0]    prg_addr_o,
  input logic [CHR_AW-1:0]    chr_addr_o,
  input logic                 mirror_h_o
);

  a_r2_load_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr_i && cpu_addr_i[15] && !cpu_addr_i[11] && !restore_i
    |=> snap_chr_o == $past(cpu_data_i));

  a_r2_load_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr_i && cpu_addr_i[15] && cpu_addr_i[11] && !restore_i
    |=> snap_main_o == $past(cpu_data_i));

  a_r3_low_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr_i && !cpu_addr_i[15] && !restore_i
    |=> $stable(snap_chr_o) && $stable(snap_main_o));

  // R10 and R11: restore loads both, regardless of a concurrent write
  a_r10_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i
    |=> snap_chr_o == $past(restore_chr_i) && snap_main_o == $past(restore_main_i));

  a_r6_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_main_o[4] |-> prg_addr_o[PRG_AW-1:PRG_OFS_W] == snap_main_o[7:5]);

  a_r7_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_main_o[4] |-> prg_addr_o[PRG_OFS_W] == cpu_addr_i[PRG_OFS_W]
                       && prg_addr_o[PRG_AW-1:PRG_OFS_W+1] == snap_main_o[7:6]);

  a_r5_lo_from_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_chr_o[7] |-> chr_addr_o[CHR_OFS_W+1:CHR_OFS_W] == snap_main_o[1:0]);

  a_r8_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mirror_h_o == snap_main_o[3]);

  a_r9_offsets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_addr_o[PRG_OFS_W-1:0] == cpu_addr_i[PRG_OFS_W-1:0]
    && chr_addr_o[CHR_OFS_W-1:0] == ppu_addr_i);

endmodule

bind multicart_mapper mcm_checker #(.PRG_OFS_W(PRG_OFS_W), .CHR_OFS_W(CHR_OFS_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cpu_addr_i     (cpu_addr_i),
  .cpu_data_i     (cpu_data_i),
  .cpu_wr_i       (cpu_wr_i),
  .ppu_addr_i     (ppu_addr_i),
  .restore_i      (restore_i),
  .restore_chr_i  (restore_chr_i),
  .restore_main_i (restore_main_i),
  .snap_chr_o     (snap_chr_o),
  .snap_main_o    (snap_main_o),
  .prg_addr_o     (prg_addr_o),
  .chr_addr_o     (chr_addr_o),
  .mirror_h_o     (mirror_h_o)
);

// File: tb/multicart_mapper_bench.sv
`timescale 1ns/1ps
module multicart_mapper_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic        cpu_wr_i = 1'b0;
  logic [12:0] ppu_addr_i = '0;
  logic        restore_i = 1'b0;
  logic [7:0]  restore_chr_i = '0;
  logic [7:0]  restore_main_i = '0;
  logic [7:0]  snap_chr_o, snap_main_o;
  logic [16:0] prg_addr_o, chr_addr_o;
  logic        mirror_h_o;

  always #2.5 clk_i = ~clk_i;

  multicart_mapper u_multicart_mapper (.*);

  typedef struct {
    string       tag;
    logic [16:0] prg;
    logic [16:0] chr;
    logic        mir;
    logic [7:0]  sa;
    logic [7:0]  sb;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] ma = '0, mb = '0;  // requirement model of the two registers

  function automatic logic [16:0] exp_prg(logic [15:0] a);
    logic [2:0] bank;
    bank = mb[4] ? {mb[7:6], a[14]} : mb[7:5];
    return {bank, a[13:0]};
  endfunction

  function automatic logic [16:0] exp_chr(logic [12:0] p);
    logic [1:0] lo;
    lo = ma[7] ? mb[1:0] : ma[1:0];
    return {ma[6], mb[2], lo, p};
  endfunction

  task automatic push(string tag);
    item_t it;
    it.tag = tag;
    it.prg = exp_prg(cpu_addr_i);
    it.chr = exp_chr(ppu_addr_i);
    it.mir = mb[3];
    it.sa  = ma;
    it.sb  = mb;
    q.push_back(it);
  endtask

  task automatic probe(string tag, logic [15:0] a, logic [12:0] p);
    @(negedge clk_i);
    cpu_wr_i = 1'b0; cpu_addr_i = a; ppu_addr_i = p;
    push(tag);
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_data_i = d; cpu_wr_i = 1'b1;
    push("R2 pre-edge unchanged");
    @(negedge clk_i);
    cpu_wr_i = 1'b0;
    if (a[15]) begin
      if (a[11]) mb = d; else ma = d;
    end
  endtask

  task automatic do_restore(logic [7:0] va, logic [7:0] vb, bit with_wr);
    @(negedge clk_i);
    restore_i = 1'b1; restore_chr_i = va; restore_main_i = vb;
    if (with_wr) begin
      cpu_addr_i = 16'h8800; cpu_data_i = 8'hFF; cpu_wr_i = 1'b1;
    end
    @(negedge clk_i);
    restore_i = 1'b0; cpu_wr_i = 1'b0;
    ma = va; mb = vb;
  endtask

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if (prg_addr_o !== it.prg || chr_addr_o !== it.chr || mirror_h_o !== it.mir ||
            snap_chr_o !== it.sa || snap_main_o !== it.sb) begin
          n_bad++;
          $display("FAIL %s: prg %h/%h chr %h/%h mir %b/%b a %h/%h b %h/%h (got/exp)",
                   it.tag, prg_addr_o, it.prg, chr_addr_o, it.chr, mirror_h_o, it.mir,
                   snap_chr_o, it.sa, snap_main_o, it.sb);
        end
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, both halves
    probe("R1 reset low half", 16'h8123, 13'h0456);
    probe("R1 reset high half", 16'hC0FE, 13'h1FFF);
    @(negedge clk_i); rst_ni = 1'b1;

    // R6 narrow program mode, R2 register select by bit 11
    do_write(16'h8800, 8'h60);
    probe("R6 bank3 low half", 16'h8001, 13'h0001);
    probe("R6 bank3 high half", 16'hFFFF, 13'h0002);

    // R7 wide mode, even and odd bank numbers
    do_write(16'h8800, 8'h90);
    probe("R7 even low half", 16'h9ABC, 13'h0ABC);
    probe("R7 even high half", 16'hD123, 13'h0123);
    do_write(16'h8800, 8'hB0);
    probe("R7 odd low half", 16'hA000, 13'h0000);
    probe("R7 odd high half", 16'hE555, 13'h1555);

    // R4 chr low bits from register A
    do_write(16'h8000, 8'h02);
    probe("R4 chr bank 2", 16'h8000, 13'h1234);

    // R5 chr low bits from register B, with A16/A15
    do_write(16'h8000, 8'hC1);
    do_write(16'h8800, 8'h07);
    probe("R5 chr bank 15", 16'hC000, 13'h0F0F);

    // R8 mirroring, R2 with other address bits set
    do_write(16'hF9AB, 8'h08);
    probe("R8 horizontal", 16'h8000, 13'h0000);
    do_write(16'hC123, 8'h41);
    probe("R2 register A via C123", 16'hB7FF, 13'h1000);

    // R3 writes below the window
    do_write(16'h7800, 8'hFF);
    do_write(16'h0000, 8'hFF);
    probe("R3 low writes ignored", 16'hC800, 13'h0800);

    // R10 restore
    do_restore(8'h42, 8'h65, 1'b0);
    probe("R10 restore low half", 16'h8F00, 13'h00F0);
    probe("R10 restore high half", 16'hCF00, 13'h1F0F);

    // R11 restore beats a same-cycle write
    do_restore(8'h00, 8'h1D, 1'b1);
    probe("R11 restore wins", 16'hC321, 13'h0321);
    do_write(16'h8800, 8'hFF);
    probe("R11 write after restore", 16'h8321, 13'h0321);

    // R9 offsets across range
    probe("R9 offset all ones", 16'hFFFF, 13'h1FFF);
    probe("R9 offset zero", 16'h8000, 13'h0000);

    // R1 asynchronous reset mid-run
    do_write(16'h8000, 8'hFF);
    @(negedge clk_i);
    rst_ni = 1'b0; ma = '0; mb = '0;
    cpu_addr_i = 16'hC444; ppu_addr_i = 13'h0444;
    push("R1 async reset mid-run");
    @(negedge clk_i); rst_ni = 1'b1;
    probe("R1 after reset release", 16'hC444, 13'h0444);

    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule